// File: doc/BRIEF.md
# Receive drop statistics counter

This block keeps diagnostic counts of received Ethernet frames that were thrown away, and presents them as a single 32-bit status word. There are two counters. The wide one counts frames discarded because no receive descriptor was free. The narrow one counts frames lost to receive FIFO overflow. The narrow one also counts runt frames, which are good frames shorter than the minimum length. Each counter has a sticky overflow flag that is set when the counter wraps.

Software reads the word through a read strobe. The data appears on the registered read output one clock later. The same read clears every field. An event that arrives in the same cycle as the read is still counted. The word is built from parameters. With the default widths, the fields sit at fixed bit positions that a register decoder can rely on.

Top module: `rx_drop_stats`

## Requirements
- R1: After reset, the read data output is zero, and a first read returns zero.
- R2: Each cycle with `nodesc_drop_i` high increments the descriptor-unavailable count, held in bits [NA-1:0] of the word (bits 15:0 at defaults), by one.
- R3: When the descriptor-unavailable count increments from its maximum, it wraps to zero and sets the flag at bit NA (bit 16). The flag stays set until the next read.
- R4: Each cycle with `fifo_ovf_i` high increments the FIFO-loss count, held in bits [NA+FW:NA+1] of the word (27:17 at defaults), by one.
- R5: A runt is counted in the FIFO-loss count on a cycle where `frame_end_i` and `frame_good_i` are both high and `frame_len_i` is between 1 and RUNT_LEN-1 (63 at defaults). A length of 0, a length of RUNT_LEN or more, a bad frame, or a missing frame-end strobe does not count.
- R6: A FIFO-overflow pulse and a runt in the same cycle add two to the FIFO-loss count. The wrap is handled modulo 2^FW, and the flag sets whenever the sum passes the maximum.
- R7: The FIFO-loss flag at bit NA+FW+1 (bit 28) sets when that count wraps and stays set until the next read.
- R8: Every bit above the FIFO-loss flag (bits 31:29 at defaults) always reads as zero.
- R9: The cycle after a read strobe, `rd_data_o` holds the word as it stood before that edge, and every field is cleared at that same edge. Without a strobe, `rd_data_o` keeps its value.
- R10: An event that coincides with a read is not lost. The read returns the old value, and the counter restarts at the event's increment (1 or 2) with its flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nodesc_drop_i | input | 1 | Pulse: frame discarded, no receive descriptor free |
| fifo_ovf_i | input | 1 | Pulse: frame lost to receive FIFO overflow |
| frame_end_i | input | 1 | Strobe: a received frame completed |
| frame_good_i | input | 1 | Completed frame had good status |
| frame_len_i | input | LEN_W | Byte length of the completed frame |
| rd_stb_i | input | 1 | Read strobe; also clears the word |
| rd_data_o | output | 32 | Registered read data |

## Verification
The bench builds the block with a 5-bit descriptor counter and a 3-bit FIFO-loss counter. At these widths, both wraps, both sticky flags and the double increment that crosses the maximum can be reached in a few dozen pulses. With these widths, the reserved field covers bits 31:10, so the zero check applies to a wide range of bits. The runt limit and the length width keep their default values, so the length boundaries at 0, 1, 63 and 64 are tested exactly as they are in the real configuration.

// File: rtl/rx_drop_stats.sv
module rx_drop_stats #(
  parameter int NA       = 16,
  parameter int FW       = 11,
  parameter int LEN_W    = 14,
  parameter int RUNT_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nodesc_drop_i,
  input  logic             fifo_ovf_i,
  input  logic             frame_end_i,
  input  logic             frame_good_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic             rd_stb_i,
  output logic [31:0]      rd_data_o
);
  localparam int USED = NA + FW + 2;
  localparam int RSVD = 32 - USED;

  logic [NA-1:0] cnt_a;
  logic          flg_a;
  logic [FW-1:0] cnt_b;
  logic          flg_b;
  logic [31:0]   word;

  logic          runt;
  logic [1:0]    inc_b;
  logic [NA:0]   sum_a;
  logic [FW:0]   sum_b;

  assign runt  = frame_end_i && frame_good_i && (frame_len_i != '0) &&
                 (frame_len_i < LEN_W'(RUNT_LEN));
  assign inc_b = 2'(fifo_ovf_i) + 2'(runt);

  assign sum_a = {1'b0, (rd_stb_i ? '0 : cnt_a)} + (NA+1)'(nodesc_drop_i);
  assign sum_b = {1'b0, (rd_stb_i ? '0 : cnt_b)} + (FW+1)'(inc_b);

  assign word = {{RSVD{1'b0}}, flg_b, cnt_b, flg_a, cnt_a};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_a     <= '0;
      flg_a     <= 1'b0;
      cnt_b     <= '0;
      flg_b     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      cnt_a <= sum_a[NA-1:0];
      flg_a <= (flg_a && !rd_stb_i) || sum_a[NA];
      cnt_b <= sum_b[FW-1:0];
      flg_b <= (flg_b && !rd_stb_i) || sum_b[FW];
      if (rd_stb_i) rd_data_o <= word;
    end
  end

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[31:USED] == '0);

  // R3
  flag_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_a && !rd_stb_i) |=> flg_a);

  // R7
  flag_b_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_b && !rd_stb_i) |=> flg_b);

  // R2
  count_a_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nodesc_drop_i && !rd_stb_i) |=> cnt_a == NA'($past(cnt_a) + 1'b1));

  // R9
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> rd_data_o == $past(word));

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> (!flg_a && !flg_b && cnt_a == NA'($past(nodesc_drop_i))));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> $stable(rd_data_o));
endmodule

// File: tb/rx_drop_stats_bench.sv
module rx_drop_stats_bench;
  localparam int NA = 5;
  localparam int FW = 3;
  localparam int LEN_W = 14;
  localparam int RUNT_LEN = 64;

  logic clk = 0;
  logic rst_n = 0;
  logic nodesc = 0, ovf = 0, fend = 0, good = 0, rd = 0;
  logic [LEN_W-1:0] len = '0;
  logic [31:0] rd_data;

  always #5 clk = ~clk;

  rx_drop_stats #(.NA(NA), .FW(FW), .LEN_W(LEN_W), .RUNT_LEN(RUNT_LEN)) u_rx_drop_stats (
    .clk(clk), .rst_n(rst_n), .nodesc_drop_i(nodesc), .fifo_ovf_i(ovf),
    .frame_end_i(fend), .frame_good_i(good), .frame_len_i(len),
    .rd_stb_i(rd), .rd_data_o(rd_data));

  int compared = 0, mismatched = 0, cycles = 0;
  int ca = 0, fa = 0, cb = 0, fb = 0;
  logic [31:0] exp_rd = '0;
  bit done = 0;

  function automatic logic [31:0] model_word();
    return (32'(fb) << (NA+FW+1)) | (32'(cb) << (NA+1)) | (32'(fa) << NA) | 32'(ca);
  endfunction

  task automatic check(string req);
    compared++;
    if (rd_data !== exp_rd) begin
      mismatched++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp_rd);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic step(bit n, bit o, bit fe, bit g, int l, bit r, string req);
    int ib;
    bit rn;
    @(negedge clk);
    nodesc = n; ovf = o; fend = fe; good = g; len = LEN_W'(l); rd = r;
    @(posedge clk);
    rn = fe && g && l >= 1 && l < RUNT_LEN;
    ib = int'(o) + int'(rn);
    if (r) begin
      exp_rd = model_word();
      ca = 0; fa = 0; cb = 0; fb = 0;
    end
    ca = ca + int'(n);
    if (ca >= (1 << NA)) begin ca -= (1 << NA); fa = 1; end
    cb = cb + ib;
    if (cb >= (1 << FW)) begin cb -= (1 << FW); fb = 1; end
    #1;
    check(req);
  endtask

  task automatic idle(string req); step(0,0,0,0,0,0,req); endtask
  task automatic rdx(string req);  step(0,0,0,0,0,1,req); endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        mismatched++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
      end
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    compared++;
    if (rd_data !== 32'h0) begin
      mismatched++;
      $display("FAIL R1: rd_data=%h expected=0", rd_data);
    end
    @(negedge clk); rst_n = 1;
    rdx("R1");
    // R2 counting
    repeat (3) step(1,0,0,0,0,0,"R2");
    rdx("R2");
    rdx("R9");
    // R4 fifo overflow
    repeat (2) step(0,1,0,0,0,0,"R4");
    idle("R9");
    rdx("R4");
    // R5 runt boundaries: only len 1 and 63 good count
    step(0,0,1,1,0,0,"R5");
    step(0,0,1,1,1,0,"R5");
    step(0,0,1,1,63,0,"R5");
    step(0,0,1,1,64,0,"R5");
    step(0,0,1,0,10,0,"R5");
    step(0,0,0,1,10,0,"R5");
    rdx("R5");
    // R3 wrap and sticky flag
    repeat ((1 << NA) + 2) step(1,0,0,0,0,0,"R3");
    idle("R3");
    rdx("R3");
    rdx("R3");
    // R6 double increment across wrap, R7 sticky
    repeat (6) step(0,1,0,0,0,0,"R6");
    step(0,1,1,1,20,0,"R6");
    step(0,1,1,1,20,0,"R7");
    idle("R7");
    rdx("R6");
    rdx("R7");
    // R10 collisions
    step(1,0,0,0,0,0,"R10");
    step(1,1,1,1,5,1,"R10");
    rdx("R10");
    step(0,1,1,1,5,1,"R10");
    rdx("R10");
    // R8 reserved bits under saturation
    repeat (40) step(1,1,1,1,3,0,"R8");
    rdx("R8");
    compared++;
    if (rd_data[31:NA+FW+2] !== '0) begin
      mismatched++;
      $display("FAIL R8: rd_data=%h expected reserved zero", rd_data);
    end
    // R9 mixed traffic
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[1], lf[2], lf[3], int'(lf[9:4]) + (lf[10] ? 40 : 0),
           lf[11] & lf[12], "R9");
    end
    rdx("R9");
    summary();
  end
endmodule